// File: doc/BRIEF.md
# Linked-List Block FIFO Allocator

This block manages the bookkeeping of a shared FIFO pool that is cut into fixed 16-byte blocks. Each channel owns a circular chain of blocks. A link table holds one next-block pointer per block. A per-channel starting pointer ties a channel to its chain. The byte datapath and the DMA engine are not part of this block. They report when a whole block has been written or read, and the block answers with the block each side must use next, the count of filled blocks, and a service request derived from a per-channel watermark.

The same module serves both directions, and a parameter selects the variant. In the receive variant, the request tells the DMA to start draining once enough blocks have filled. In the transmit variant, the request asks the DMA to refill once few enough filled blocks remain. Writing into a full chain is refused and reported as an overflow. Reading from an empty channel is refused and reported as an underflow.

Top module: `fifo_ll_alloc`

## Requirements
- R1: After reset, every channel's write cursor, read cursor, occupancy and watermark are 0. ovf_o and unf_o are low. svc_req_o is 0 in the receive variant and 1 in the transmit variant.
- R2: A cycle with cfg_link_we_i high stores cfg_next_i as the successor of block cfg_blk_i. Every later cursor advance out of that block moves to the stored successor.
- R3: A cycle with cfg_start_we_i high sets the write and read cursors of channel cfg_ch_i to cfg_start_i and clears its occupancy on the next edge. This takes precedence over any completion on that channel in the same cycle, and such a completion raises no error.
- R4: A write completion (wr_done_i, channel wr_ch_i) moves that channel's write cursor to the successor block and raises its occupancy by one, visible after the next edge.
- R5: A read completion (rd_done_i, channel rd_ch_i) on a channel with nonzero occupancy moves its read cursor to the successor block and lowers its occupancy by one.
- R6: A write completion and a valid read completion on the same channel in the same cycle advance both cursors and leave the occupancy unchanged.
- R7: A write completion whose successor block is the current read block, while the occupancy is nonzero and no valid read completion on that channel occurs in the same cycle, is dropped. The write cursor and occupancy do not change, and ovf_o is high for exactly the following cycle.
- R8: A read completion on a channel with zero occupancy is dropped. The read cursor does not change, and unf_o is high for exactly the following cycle.
- R9: cfg_wm_we_i stores cfg_wm_i as the watermark of channel cfg_ch_i. In the receive variant (IS_RX=1), the channel's svc_req_o bit is 1 when the watermark is nonzero and the occupancy is at least the watermark.
- R10: In the transmit variant (IS_RX=0), a channel's svc_req_o bit is 1 when its occupancy is at most its watermark.
- R11: Channels are independent. A write completion on one channel and a read completion on another in the same cycle each take effect, or raise their own error, without touching any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_link_we_i | input | 1 | Write a link table entry |
| cfg_blk_i | input | PTR_W | Block whose successor is written |
| cfg_next_i | input | PTR_W | Successor block value |
| cfg_start_we_i | input | 1 | Bind channel cfg_ch_i to a starting block |
| cfg_wm_we_i | input | 1 | Write the watermark of channel cfg_ch_i |
| cfg_ch_i | input | CH_W | Channel addressed by start and watermark writes |
| cfg_start_i | input | PTR_W | Starting block value |
| cfg_wm_i | input | CNT_W | Watermark value in blocks |
| wr_done_i | input | 1 | A block was completely written |
| wr_ch_i | input | CH_W | Channel of the write completion |
| rd_done_i | input | 1 | A block was completely read |
| rd_ch_i | input | CH_W | Channel of the read completion |
| wr_blk_o | output | NUM_CH*PTR_W | Per-channel block being written |
| rd_blk_o | output | NUM_CH*PTR_W | Per-channel block being read |
| occ_o | output | NUM_CH*CNT_W | Per-channel count of filled blocks |
| svc_req_o | output | NUM_CH | Per-channel watermark service request |
| ovf_o | output | 1 | One-cycle pulse: a write completion was refused |
| unf_o | output | 1 | One-cycle pulse: a read completion was refused |

## Verification
A write completion and a read completion on the same channel can fall in the same cycle. This matters most when the chain is full, because the read frees exactly the block the writer is about to enter. The bench fills a four-block chain to three blocks, then issues a lone write, which must be refused with an overflow pulse. It then issues a write and a read together, which must both advance with the occupancy held at three and no error. The reverse collision, a read on an empty channel during a write on another channel, is also driven, and the bench judges the two channels separately.

// File: rtl/fifo_ll_pkg.sv
package fifo_ll_pkg;
  typedef struct packed {
    logic ovf;
    logic unf;
  } fll_evt_t;
endpackage

// File: rtl/fifo_ll_link_ram.sv
module fifo_ll_link_ram #(
  parameter int NUM_BLOCKS = 512,
  parameter int PTR_W      = 10
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [PTR_W-1:0] wdata_i,
  input  logic [PTR_W-1:0] raddr_a_i,
  output logic [PTR_W-1:0] rdata_a_o,
  input  logic [PTR_W-1:0] raddr_b_i,
  output logic [PTR_W-1:0] rdata_b_o
);
  localparam int IDX_W = $clog2(NUM_BLOCKS);
  localparam logic [PTR_W:0] NB = NUM_BLOCKS[PTR_W:0];

  logic [PTR_W-1:0] mem [NUM_BLOCKS];

  // out-of-pool writes are discarded
  always_ff @(posedge clk_i) begin
    if (we_i && ({1'b0, waddr_i} < NB)) mem[waddr_i[IDX_W-1:0]] <= wdata_i;
  end

  assign rdata_a_o = ({1'b0, raddr_a_i} < NB) ? mem[raddr_a_i[IDX_W-1:0]] : '0;
  assign rdata_b_o = ({1'b0, raddr_b_i} < NB) ? mem[raddr_b_i[IDX_W-1:0]] : '0;
endmodule

// File: rtl/fifo_ll_chan.sv
module fifo_ll_chan
  import fifo_ll_pkg::*;
#(
  parameter int PTR_W = 10,
  parameter int CNT_W = 10,
  parameter bit IS_RX = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_we_i,
  input  logic [PTR_W-1:0] start_i,
  input  logic             wm_we_i,
  input  logic [CNT_W-1:0] wm_i,
  input  logic             wr_hit_i,
  input  logic [PTR_W-1:0] wr_next_i,
  input  logic             rd_hit_i,
  input  logic [PTR_W-1:0] rd_next_i,
  output logic [PTR_W-1:0] wr_blk_o,
  output logic [PTR_W-1:0] rd_blk_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             svc_o,
  output fll_evt_t         evt_o
);
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q, wm_q;
  logic             rd_ok, wr_ok, full;

  assign rd_ok = rd_hit_i && (cnt_q != '0) && !start_we_i;
  // successor equal to the block under read means the chain is full
  assign full  = (wr_next_i == rd_q) && (cnt_q != '0);
  assign wr_ok = wr_hit_i && !start_we_i && !(full && !rd_ok);

  assign evt_o.ovf = wr_hit_i && !start_we_i && full && !rd_ok;
  assign evt_o.unf = rd_hit_i && !start_we_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (start_we_i) begin
      wr_q  <= start_i;
      rd_q  <= start_i;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wr_q <= wr_next_i;
      if (rd_ok) rd_q <= rd_next_i;
      unique case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wm_q <= '0;
    else if (wm_we_i) wm_q <= wm_i;
  end

  generate
    if (IS_RX) begin : g_drain
      assign svc_o = (wm_q != '0) && (cnt_q >= wm_q);
      p_drain_needs_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        svc_o |-> (cnt_o != '0));
    end else begin : g_refill
      assign svc_o = (cnt_q <= wm_q);
      p_refill_when_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_o == '0) |-> svc_o);
    end
  endgenerate

  assign wr_blk_o = wr_q;
  assign rd_blk_o = rd_q;
  assign cnt_o    = cnt_q;

  p_start_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_we_i |=> (cnt_o == '0) && (wr_blk_o == rd_blk_o));
  p_ovf_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.ovf |=> $stable(wr_blk_o) && $stable(cnt_o));
  p_unf_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.unf |=> $stable(rd_blk_o));
  p_pair_keeps_cnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && rd_hit_i && !start_we_i && cnt_o != '0) |=> $stable(cnt_o));
endmodule

// File: rtl/fifo_ll_alloc.sv
module fifo_ll_alloc
  import fifo_ll_pkg::*;
#(
  parameter int NUM_BLOCKS = 512,
  parameter int PTR_W      = 10,
  parameter int NUM_CH     = 4,
  parameter bit IS_RX      = 1'b1,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_link_we_i,
  input  logic [PTR_W-1:0]        cfg_blk_i,
  input  logic [PTR_W-1:0]        cfg_next_i,
  input  logic                    cfg_start_we_i,
  input  logic                    cfg_wm_we_i,
  input  logic [CH_W-1:0]         cfg_ch_i,
  input  logic [PTR_W-1:0]        cfg_start_i,
  input  logic [CNT_W-1:0]        cfg_wm_i,
  input  logic                    wr_done_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic                    rd_done_i,
  input  logic [CH_W-1:0]         rd_ch_i,
  output logic [NUM_CH*PTR_W-1:0] wr_blk_o,
  output logic [NUM_CH*PTR_W-1:0] rd_blk_o,
  output logic [NUM_CH*CNT_W-1:0] occ_o,
  output logic [NUM_CH-1:0]       svc_req_o,
  output logic                    ovf_o,
  output logic                    unf_o
);
  logic [PTR_W-1:0] wr_cur [NUM_CH];
  logic [PTR_W-1:0] rd_cur [NUM_CH];
  logic [NUM_CH-1:0] ovf_vec, unf_vec;
  logic [PTR_W-1:0] wr_sel, rd_sel, wr_succ, rd_succ;

  // one lookup port per side: only the addressed channel can advance
  assign wr_sel = wr_cur[wr_ch_i];
  assign rd_sel = rd_cur[rd_ch_i];

  fifo_ll_link_ram #(.NUM_BLOCKS(NUM_BLOCKS), .PTR_W(PTR_W)) u_link (
    .clk_i     (clk_i),
    .we_i      (cfg_link_we_i),
    .waddr_i   (cfg_blk_i),
    .wdata_i   (cfg_next_i),
    .raddr_a_i (wr_sel),
    .rdata_a_o (wr_succ),
    .raddr_b_i (rd_sel),
    .rdata_b_o (rd_succ)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fll_evt_t evt;
    fifo_ll_chan #(.PTR_W(PTR_W), .CNT_W(CNT_W), .IS_RX(IS_RX)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_we_i (cfg_start_we_i && (cfg_ch_i == CH_W'(g))),
      .start_i    (cfg_start_i),
      .wm_we_i    (cfg_wm_we_i && (cfg_ch_i == CH_W'(g))),
      .wm_i       (cfg_wm_i),
      .wr_hit_i   (wr_done_i && (wr_ch_i == CH_W'(g))),
      .wr_next_i  (wr_succ),
      .rd_hit_i   (rd_done_i && (rd_ch_i == CH_W'(g))),
      .rd_next_i  (rd_succ),
      .wr_blk_o   (wr_cur[g]),
      .rd_blk_o   (rd_cur[g]),
      .cnt_o      (occ_o[g*CNT_W +: CNT_W]),
      .svc_o      (svc_req_o[g]),
      .evt_o      (evt)
    );
    assign ovf_vec[g] = evt.ovf;
    assign unf_vec[g] = evt.unf;
    assign wr_blk_o[g*PTR_W +: PTR_W] = wr_cur[g];
    assign rd_blk_o[g*PTR_W +: PTR_W] = rd_cur[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= |ovf_vec;
      unf_o <= |unf_vec;
    end
  end

  p_ovf_from_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(wr_done_i));
  p_unf_from_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> $past(rd_done_i));
endmodule

// File: tb/sim_fifo_ll_alloc.sv
`timescale 1ns/1ps
module sim_fifo_ll_alloc;
  localparam int NB = 512, PW = 10, NC = 4, CW = 2, KW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          lwe = 0, swe = 0, wwe = 0, wd = 0, rdn = 0;
  logic [PW-1:0] lblk = 0, lnext = 0, sval = 0;
  logic [KW-1:0] wval = 0;
  logic [CW-1:0] cch = 0, wch = 0, rch = 0;
  logic [NC*PW-1:0] wb0, rb0, wb1, rb1;
  logic [NC*KW-1:0] oc0, oc1;
  logic [NC-1:0] sv0, sv1;
  logic ov0, un0, ov1, un1;

  fifo_ll_alloc #(.NUM_BLOCKS(NB), .PTR_W(PW), .NUM_CH(NC), .IS_RX(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_link_we_i(lwe), .cfg_blk_i(lblk), .cfg_next_i(lnext),
    .cfg_start_we_i(swe), .cfg_wm_we_i(wwe), .cfg_ch_i(cch), .cfg_start_i(sval), .cfg_wm_i(wval),
    .wr_done_i(wd), .wr_ch_i(wch), .rd_done_i(rdn), .rd_ch_i(rch),
    .wr_blk_o(wb0), .rd_blk_o(rb0), .occ_o(oc0), .svc_req_o(sv0), .ovf_o(ov0), .unf_o(un0));

  fifo_ll_alloc #(.NUM_BLOCKS(NB), .PTR_W(PW), .NUM_CH(NC), .IS_RX(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_link_we_i(lwe), .cfg_blk_i(lblk), .cfg_next_i(lnext),
    .cfg_start_we_i(swe), .cfg_wm_we_i(wwe), .cfg_ch_i(cch), .cfg_start_i(sval), .cfg_wm_i(wval),
    .wr_done_i(wd), .wr_ch_i(wch), .rd_done_i(rdn), .rd_ch_i(rch),
    .wr_blk_o(wb1), .rd_blk_o(rb1), .occ_o(oc1), .svc_req_o(sv1), .ovf_o(ov1), .unf_o(un1));

  typedef struct {
    string tag; int ch; int wr; int rd; int cnt; bit srx; bit stx; bit ovf; bit unf;
  } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state built from the requirements
  int m_link[NB];
  int m_wr[NC], m_rd[NC], m_cnt[NC], m_wm[NC];
  bit m_ovf, m_unf;

  task automatic drive(bit l_we, int l_b, int l_n, bit s_we, bit w_we, int c, int s, int w,
                       bit wdo, int wc, bit rdo, int rc);
    @(negedge clk);
    lwe = l_we; lblk = PW'(l_b); lnext = PW'(l_n);
    swe = s_we; wwe = w_we; cch = CW'(c); sval = PW'(s); wval = KW'(w);
    wd = wdo; wch = CW'(wc); rdn = rdo; rch = CW'(rc);
    m_ovf = 0; m_unf = 0;
    for (int k = 0; k < NC; k++) begin
      bit wh, rh, rok, full;
      if (s_we && c == k) begin
        m_wr[k] = s; m_rd[k] = s; m_cnt[k] = 0;
      end else begin
        wh = wdo && wc == k; rh = rdo && rc == k;
        rok = rh && m_cnt[k] != 0;
        full = (m_link[m_wr[k]] == m_rd[k]) && m_cnt[k] != 0;
        if (rh && m_cnt[k] == 0) m_unf = 1;
        if (wh && full && !rok) m_ovf = 1;
        if (wh && !(full && !rok)) begin m_wr[k] = m_link[m_wr[k]]; m_cnt[k]++; end
        if (rok) begin m_rd[k] = m_link[m_rd[k]]; m_cnt[k]--; end
      end
      if (w_we && c == k) m_wm[k] = w;
    end
    if (l_we) m_link[l_b] = l_n;
  endtask

  task automatic idle(); drive(0,0,0, 0,0,0,0,0, 0,0,0,0); endtask
  task automatic link(int b, int n); drive(1,b,n, 0,0,0,0,0, 0,0,0,0); endtask
  task automatic bind_start(int c, int s); drive(0,0,0, 1,0,c,s,0, 0,0,0,0); endtask
  task automatic set_wm(int c, int w); drive(0,0,0, 0,1,c,0,w, 0,0,0,0); endtask
  task automatic xfer(bit w, int wc, bit r, int rc); drive(0,0,0, 0,0,0,0,0, w,wc,r,rc); endtask

  task automatic expect_ch(int c, string tag);
    exp_t e;
    e.tag = tag; e.ch = c; e.wr = m_wr[c]; e.rd = m_rd[c]; e.cnt = m_cnt[c];
    e.srx = (m_wm[c] != 0) && (m_cnt[c] >= m_wm[c]);
    e.stx = (m_cnt[c] <= m_wm[c]);
    e.ovf = m_ovf; e.unf = m_unf;
    q.push_back(e);
  endtask

  // monitor: samples mid high phase, after the edge the driver aimed at
  always @(posedge clk) begin
    exp_t e;
    int aw, ar, ac;
    #5;
    while (q.size() > 0) begin
      e = q.pop_front();
      aw = int'(wb0[e.ch*PW +: PW]); ar = int'(rb0[e.ch*PW +: PW]); ac = int'(oc0[e.ch*KW +: KW]);
      n_chk++;
      if (aw != e.wr || ar != e.rd || ac != e.cnt || sv0[e.ch] != e.srx || sv1[e.ch] != e.stx ||
          ov0 != e.ovf || un0 != e.unf) begin
        n_bad++;
        $display("FAIL %s ch%0d actual wr=%0d rd=%0d cnt=%0d rx=%0b tx=%0b ovf=%0b unf=%0b expected wr=%0d rd=%0d cnt=%0d rx=%0b tx=%0b ovf=%0b unf=%0b",
                 e.tag, e.ch, aw, ar, ac, sv0[e.ch], sv1[e.ch], ov0, un0,
                 e.wr, e.rd, e.cnt, e.srx, e.stx, e.ovf, e.unf);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NC; k++) begin m_wr[k] = 0; m_rd[k] = 0; m_cnt[k] = 0; m_wm[k] = 0; end
    m_ovf = 0; m_unf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    for (int k = 0; k < NC; k++) expect_ch(k, "R1 reset");

    // R2: two four-block chains 8..11 and 20..23
    for (int b = 0; b < 4; b++) link(8 + b, 8 + ((b + 1) % 4));
    for (int b = 0; b < 4; b++) link(20 + b, 20 + ((b + 1) % 4));
    bind_start(1, 8);  expect_ch(1, "R3 start");
    bind_start(2, 20); expect_ch(2, "R3 start");
    set_wm(1, 2);      expect_ch(1, "R9 wm write");

    xfer(1,1, 0,0); expect_ch(1, "R4 R2 write");
    xfer(1,1, 0,0); expect_ch(1, "R9 R10 drain at wm");
    xfer(1,1, 0,0); expect_ch(1, "R10 refill off");
    xfer(1,1, 0,0); expect_ch(1, "R7 overflow");
    idle();         expect_ch(1, "R7 pulse ends");
    xfer(1,1, 1,1); expect_ch(1, "R6 pair at full");
    xfer(0,0, 1,1); expect_ch(1, "R5 read");
    xfer(0,0, 1,1); expect_ch(1, "R5 read");
    xfer(0,0, 1,1); expect_ch(1, "R5 read to empty");
    xfer(0,0, 1,1); expect_ch(1, "R8 underflow");
    idle();         expect_ch(1, "R8 pulse ends");

    xfer(1,2, 1,1); expect_ch(1, "R11 R8 rd empty ch"); expect_ch(2, "R11 wr other ch");
    expect_ch(0, "R11 untouched ch");
    xfer(1,2, 1,2); expect_ch(2, "R6 pair ch2");

    drive(0,0,0, 1,0,2,20,0, 1,2,0,0); expect_ch(2, "R3 start wins");
    set_wm(2, 0);
    xfer(1,2, 0,0); expect_ch(2, "R9 zero wm no drain");

    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule